// File: doc/BRIEF.md
# Wavefront Lane Swizzle Crossbar

This block moves 32-bit values between the lanes of a 32-lane wavefront in one registered step. Each request carries every lane's data word, a mask of the lanes that are active, a mode code and that mode's parameters. Every output lane is filled from one source lane that the mode picks. If the source lane is inactive, the output lane gets zero.

There are five mapping modes. Quad permute uses one selector per quad position. Bitmask permute rewrites each bit of the lane number. Group broadcast copies one lane to its whole group. Group swap exchanges neighbouring groups. Group reverse mirrors lane order inside each group. A request with a bad mode code or bad parameters does not remap anything: the data comes out unchanged and an error flag is raised. Results appear one clock after the request strobe, together with an output valid.

Top module: `lane_xchg`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid`, `out_err` and every bit of `out_data` are 0.
- R2: Mode 0 (quad permute): lane L reads lane 4*(L/4) + s, where s is `in_quad_sel[2p+1:2p]` and p = L mod 4.
- R3: Mode 1 (bitmask permute): bit k of the source lane number comes from bit k of L under op `in_bit_ops[2k+1:2k]`. The ops are 00 = force 0, 01 = force 1, 10 = keep, 11 = invert.
- R4: Mode 2 (broadcast): with group size G from `in_grp` (2, 4, 8, 16 or 32) and `in_idx` < G, lane L reads lane G*(L/G) + `in_idx`.
- R5: Mode 3 (swap): with G in {1, 2, 4, 8, 16}, lane L reads L+G when L/G is even and L-G when L/G is odd.
- R6: Mode 4 (reverse): with G in {2, 4, 8, 16, 32}, lane L reads G*(L/G) + (G-1 - L mod G).
- R7: When the source lane's bit in `in_active` is 0, the output lane is zero. The mask is applied by source lane, not by destination lane.
- R8: A mode code of 5 to 7, a group size outside the set allowed for the mode, or a broadcast index not below G sets `out_err`. In that case `out_data` equals the input data unchanged and the mask is not applied. A legal request clears `out_err`.
- R9: `out_valid` is `in_valid` delayed by exactly one cycle. In a cycle with no strobe, `out_data` and `out_err` keep their values.
- R10: The all-zero control word is legal (mode 0 with all selectors 0). With it, every lane takes the value of lane 0 of its own quad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 3 | Mapping mode code |
| in_quad_sel | input | 8 | Four 2-bit quad selectors, position p at bits 2p+1:2p |
| in_bit_ops | input | 10 | Five 2-bit lane-number bit ops, bit k at 2k+1:2k |
| in_grp | input | 6 | Group size G for broadcast, swap and reverse |
| in_idx | input | 5 | Broadcast lane index within the group |
| in_active | input | 32 | Active-lane mask, bit L for lane L |
| in_data | input | 1024 | Lane data, lane L at bits 32L+31:32L |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_err | output | 1 | Illegal mode or parameter on the reported request |
| out_data | output | 1024 | Exchanged lane data, same packing as the input |

## Verification
The assertions assume that `rst_n` is held for at least one clock edge before the first strobe. They also assume that the inputs hold steady around each sampling edge. `in_grp` and `in_idx` may be any value: out-of-range values are part of the error behaviour being checked, not something the stimulus avoids. The bench drives all inputs on the falling edge and raises the strobe for exactly one cycle per request. It then leaves one idle cycle before the next request, so both the hold behaviour and the one-cycle lag are observed at the ports.

// File: rtl/lane_xchg_pkg.sv
package lane_xchg_pkg;
   typedef enum logic [2:0] {
      XM_QUAD  = 3'd0,
      XM_BITS  = 3'd1,
      XM_BCAST = 3'd2,
      XM_SWAP  = 3'd3,
      XM_REV   = 3'd4
   } xchg_mode_e;

   typedef enum logic [1:0] {
      BOP_ZERO = 2'd0,
      BOP_ONE  = 2'd1,
      BOP_KEEP = 2'd2,
      BOP_FLIP = 2'd3
   } bit_op_e;
endpackage

// File: rtl/lane_xchg_chk.sv
module lane_xchg_chk
   import lane_xchg_pkg::*;
#(
   parameter int LANES  = 32,
   parameter int LANE_W = $clog2(LANES)
) (
   input  logic [2:0]      mode,
   input  logic [LANE_W:0] grp,
   input  logic [LANE_W-1:0] idx,
   output logic            legal
);
   localparam logic [LANE_W:0] FULL = LANE_W'(0) + (LANE_W+1)'(LANES);
   localparam logic [LANE_W:0] HALF = (LANE_W+1)'(LANES / 2);

   logic pow2;
   logic idx_fits;

   always_comb begin
      pow2     = (grp != '0) && ((grp & (grp - 1'b1)) == '0);
      idx_fits = ({1'b0, idx} < grp);
      case (mode)
         XM_QUAD, XM_BITS: legal = 1'b1;
         XM_BCAST:         legal = pow2 && (grp >= 2) && (grp <= FULL) && idx_fits;
         XM_SWAP:          legal = pow2 && (grp <= HALF);
         XM_REV:           legal = pow2 && (grp >= 2) && (grp <= FULL);
         default:          legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/lane_xchg_src.sv
module lane_xchg_src
   import lane_xchg_pkg::*;
#(
   parameter int LANES   = 32,
   parameter int LANE_W  = $clog2(LANES),
   parameter int LANE_ID = 0
) (
   input  logic [2:0]          mode,
   input  logic [7:0]          quad_sel,
   input  logic [2*LANE_W-1:0] bit_ops,
   input  logic [LANE_W:0]     grp,
   input  logic [LANE_W-1:0]   idx,
   output logic [LANE_W-1:0]   src
);
   localparam logic [LANE_W-1:0] ME = LANE_W'(LANE_ID);
   localparam int                QP = LANE_ID % 4;

   logic [LANE_W-1:0] gmask;
   logic [LANE_W-1:0] bits_src;

   always_comb begin
      for (int k = 0; k < LANE_W; k++) begin
         case (bit_op_e'(bit_ops[2*k +: 2]))
            BOP_ZERO: bits_src[k] = 1'b0;
            BOP_ONE:  bits_src[k] = 1'b1;
            BOP_KEEP: bits_src[k] = ME[k];
            default:  bits_src[k] = ~ME[k];
         endcase
      end
   end

   always_comb begin
      gmask = LANE_W'(grp - 1'b1);
      case (mode)
         XM_QUAD:  src = {ME[LANE_W-1:2], quad_sel[2*QP +: 2]};
         XM_BITS:  src = bits_src;
         XM_BCAST: src = (ME & ~gmask) | (idx & gmask);
         XM_SWAP:  src = ME ^ LANE_W'(grp);
         XM_REV:   src = ME ^ gmask;
         default:  src = ME;
      endcase
   end
endmodule

// File: rtl/lane_xchg.sv
module lane_xchg
   import lane_xchg_pkg::*;
#(
   parameter int LANES  = 32,
   parameter int DATA_W = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [2:0]                in_mode,
   input  logic [7:0]                in_quad_sel,
   input  logic [2*$clog2(LANES)-1:0] in_bit_ops,
   input  logic [$clog2(LANES):0]    in_grp,
   input  logic [$clog2(LANES)-1:0]  in_idx,
   input  logic [LANES-1:0]          in_active,
   input  logic [LANES*DATA_W-1:0]   in_data,
   output logic                      out_valid,
   output logic                      out_err,
   output logic [LANES*DATA_W-1:0]   out_data
);
   localparam int LANE_W = $clog2(LANES);
   localparam int VEC_W  = LANES * DATA_W;

   if (LANES < 4 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("lane_xchg: LANES must be a power of two of at least 4");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("lane_xchg: DATA_W must be positive");
   end

   logic             legal;
   logic [VEC_W-1:0] mapped;

   lane_xchg_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
      .mode  (in_mode),
      .grp   (in_grp),
      .idx   (in_idx),
      .legal (legal)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] src;
      logic [DATA_W-1:0] picked;

      lane_xchg_src #(.LANES(LANES), .LANE_W(LANE_W), .LANE_ID(l)) u_src (
         .mode     (in_mode),
         .quad_sel (in_quad_sel),
         .bit_ops  (in_bit_ops),
         .grp      (in_grp),
         .idx      (in_idx),
         .src      (src)
      );

      always_comb begin
         picked = in_data[src*DATA_W +: DATA_W];
         if (!legal)
            mapped[l*DATA_W +: DATA_W] = in_data[l*DATA_W +: DATA_W];
         else if (in_active[src])
            mapped[l*DATA_W +: DATA_W] = picked;
         else
            mapped[l*DATA_W +: DATA_W] = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_err   <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_err  <= ~legal;
            out_data <= mapped;
         end
      end
   end

   AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                             // R9
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                                           // R9
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_data) && $stable(out_err)));              // R9
   AST_ERR_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !legal) |=> (out_err && out_data == $past(in_data)));   // R8
   AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode > 3'd4) |=> out_err);                           // R8
   AST_DEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && legal && in_active == '0) |=> (out_data == '0));        // R7
endmodule

// File: tb/lane_xchg_tb.sv
`timescale 1ns/1ps
module lane_xchg_tb;
   localparam int N = 32;
   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic [2:0]    in_mode;
   logic [7:0]    in_quad_sel;
   logic [9:0]    in_bit_ops;
   logic [5:0]    in_grp;
   logic [4:0]    in_idx;
   logic [N-1:0]  in_active;
   logic [N*W-1:0] in_data;
   logic          out_valid;
   logic          out_err;
   logic [N*W-1:0] out_data;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   lane_xchg u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
      .in_quad_sel(in_quad_sel), .in_bit_ops(in_bit_ops), .in_grp(in_grp),
      .in_idx(in_idx), .in_active(in_active), .in_data(in_data),
      .out_valid(out_valid), .out_err(out_err), .out_data(out_data)
   );

   task automatic check(input bit ok, input string req, input logic [N*W-1:0] act,
                        input logic [N*W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit is_p2(input int g);
      return (g == 1 || g == 2 || g == 4 || g == 8 || g == 16 || g == 32);
   endfunction

   function automatic bit ref_legal(input int m, input int g, input int ix);
      case (m)
         0, 1: return 1;
         2: return is_p2(g) && g >= 2 && ix < g;
         3: return is_p2(g) && g <= 16;
         4: return is_p2(g) && g >= 2;
         default: return 0;
      endcase
   endfunction

   function automatic int ref_src(input int m, input int l, input logic [7:0] qs,
                                  input logic [9:0] ops, input int g, input int ix);
      int r;
      case (m)
         0: r = (l / 4) * 4 + int'(qs[(l % 4) * 2 +: 2]);
         1: begin
            r = 0;
            for (int k = 0; k < 5; k++) begin
               int b;
               b = (l >> k) & 1;
               case (ops[2*k +: 2])
                  2'b00: b = 0;
                  2'b01: b = 1;
                  2'b10: b = b;
                  default: b = 1 - b;
               endcase
               r = r + (b << k);
            end
         end
         2: r = (l / g) * g + ix;
         3: r = (((l / g) % 2) == 0) ? l + g : l - g;
         default: r = (l / g) * g + (g - 1 - (l % g));
      endcase
      return r;
   endfunction

   task automatic run(input string req, input int m, input logic [7:0] qs,
                      input logic [9:0] ops, input int g, input int ix,
                      input logic [N-1:0] act, input int seed);
      logic [N*W-1:0] din;
      logic [N*W-1:0] exp;
      logic [N*W-1:0] held;
      bit             lg;
      for (int l = 0; l < N; l++)
         din[l*W +: W] = {16'(seed * 7 + 3), 8'(l), 8'(l ^ 8'h5a)};
      lg = ref_legal(m, g, ix);
      for (int l = 0; l < N; l++) begin
         int s;
         if (!lg) exp[l*W +: W] = din[l*W +: W];
         else begin
            s = ref_src(m, l, qs, ops, g, ix);
            exp[l*W +: W] = act[s] ? din[s*W +: W] : '0;
         end
      end
      @(negedge clk);
      in_valid = 1'b1; in_mode = 3'(m); in_quad_sel = qs; in_bit_ops = ops;
      in_grp = 6'(g); in_idx = 5'(ix); in_active = act; in_data = din;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid === 1'b1, {req, " R9 valid lag"}, N*W'(out_valid), 1);
      check(out_err === !lg, {req, " R8 error flag"}, N*W'(out_err), N*W'(!lg));
      check(out_data === exp, {req, " data"}, out_data, exp);
      held = out_data;
      in_data = ~din;
      @(negedge clk);
      check(out_valid === 1'b0 && out_data === held, {req, " R9 idle hold"}, out_data, held);
   endtask

   task automatic t_reset();
      check(out_valid === 1'b0 && out_err === 1'b0 && out_data === '0, "R1 reset state",
            out_data, '0);
   endtask

   task automatic t_quad();
      run("R2 quad reversed", 0, {2'd0, 2'd1, 2'd2, 2'd3}, '0, 0, 0, '1, 1);
      run("R2 quad mixed", 0, {2'd2, 2'd2, 2'd0, 2'd1}, '0, 0, 0, '1, 2);
   endtask

   task automatic t_bits();
      run("R3 bitmask mixed", 1, '0, {2'b10, 2'b11, 2'b01, 2'b00, 2'b10}, 0, 0, '1, 3);
      run("R3 bitmask invert all", 1, '0, 10'b11_11_11_11_11, 0, 0, '1, 4);
   endtask

   task automatic t_bcast();
      run("R4 broadcast g8 i5", 2, '0, '0, 8, 5, '1, 5);
      run("R4 broadcast g32 i31", 2, '0, '0, 32, 31, '1, 6);
   endtask

   task automatic t_swap();
      run("R5 swap g1", 3, '0, '0, 1, 0, '1, 7);
      run("R5 swap g16", 3, '0, '0, 16, 0, '1, 8);
   endtask

   task automatic t_rev();
      run("R6 reverse g2", 4, '0, '0, 2, 0, '1, 9);
      run("R6 reverse g32", 4, '0, '0, 32, 0, '1, 10);
   endtask

   task automatic t_mask();
      run("R7 inactive source reverse", 4, '0, '0, 2, 0, 32'h5555_5555, 11);
      run("R7 none active", 2, '0, '0, 4, 1, '0, 12);
   endtask

   task automatic t_err();
      run("R8 bcast idx at G", 2, '0, '0, 8, 8, 32'h0f0f_0f0f, 13);
      run("R8 reverse G6", 4, '0, '0, 6, 0, '1, 14);
      run("R8 swap G32", 3, '0, '0, 32, 0, '1, 15);
      run("R8 mode 7", 7, '0, '0, 4, 0, '1, 16);
      run("R8 legal clears flag", 3, '0, '0, 4, 0, '1, 17);
   endtask

   task automatic t_default();
      run("R10 all-zero control", 0, '0, '0, 0, 0, '1, 18);
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_mode = '0; in_quad_sel = '0; in_bit_ops = '0;
      in_grp = '0; in_idx = '0; in_active = '0; in_data = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_quad();
      t_bits();
      t_bcast();
      t_swap();
      t_rev();
      t_mask();
      t_err();
      t_default();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule